// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block watches a processor's load/store access bus and flags an access before it is performed when the access falls inside one of a few programmable watch regions. Each channel holds a watch address and a control word. The control word carries a write-trigger enable, a read-trigger enable and a six-bit compare field that chooses which low address bits take part in the match. Address bits above the field are always compared.

Software configures a channel through an indexed write port. One select picks the channel, and a kind bit picks the address word or the control word. On any access cycle the block drives a combinational break flag and the number of the triggering channel, and debug entry logic uses both. When several channels match, the lowest-numbered one is reported. A compare field whose ones are not one contiguous run from the top is cut at its highest zero. As a result, every channel always covers a naturally aligned power-of-two region.

Top module: `dbk_comparator`

## Requirements
- R1: After synchronous reset every channel is inactive (both enables clear, address zero), so no access raises `brk_hit`.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_wdata` is stored into channel `cfg_sel`: the address word when `cfg_kind` is 0, the control word when `cfg_kind` is 1. The new value governs matching from the cycle after that edge, and the old value governs the write cycle itself.
- R3: Control bit 31 enables triggering on writes. An access with `acc_wr` high can hit a channel only when this bit is set.
- R4: Control bit 30 enables triggering on reads. An access with `acc_rd` high can hit a channel only when this bit is set.
- R5: A channel whose control bits 31 and 30 are both clear never hits, whatever its address.
- R6: Control bits [5:0] form the compare field. Address bit i (i < 6) is compared when field bit i is one and ignored when it is zero. Address bits 6 and above are always compared. A hit requires (access address & mask) == (stored address & mask).
- R7: If the field's ones are not a single run starting at bit 5, only the ones above the highest zero are kept. For example, field 110100 ignores address bits [3:0], and field 011111 ignores bits [5:0].
- R8: `brk_hit` depends combinationally on the access inputs, within the same cycle as `acc_valid`, and it is low whenever `acc_valid` is low.
- R9: When several channels hit, `brk_chan` gives the lowest-numbered one. When nothing hits, `brk_chan` is 0.
- R10: An access with both `acc_rd` and `acc_wr` high hits a matching channel that has either enable set.
- R11: A configuration write whose `cfg_sel` is not below the channel count changes no channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Channel index of the write |
| cfg_kind | input | 1 | 0 = address word, 1 = control word |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_rd | input | 1 | Access reads memory |
| acc_wr | input | 1 | Access writes memory |
| brk_hit | output | 1 | Break before the access |
| brk_chan | output | SEL_W | Lowest hitting channel, 0 when idle |

## Verification
The bench builds the block with three channels rather than the default two. This makes the select two bits wide, so the index 3 becomes reachable and a write to a channel that does not exist (R11) can actually be driven. Three channels also let the priority case walk across a three-way overlap, removing the winner twice. The address width stays at 32 and the field at six bits, so truncated compare fields such as 110100 and 011111 can be checked against known region boundaries.

// File: rtl/dbk_pkg.sv
`timescale 1ns/1ps
package dbk_pkg;

    localparam int CFG_W      = 32;
    localparam int ST_EN_BIT  = 31;
    localparam int LD_EN_BIT  = 30;

    typedef enum logic {
        CFG_ADDR = 1'b0,
        CFG_CTRL = 1'b1
    } cfg_kind_e;

    // Number of consecutive ones in field[width-1:0] counted from its top bit.
    function automatic int top_run(input logic [CFG_W-1:0] field, input int width);
        int  run;
        bit  stop;
        run  = 0;
        stop = 1'b0;
        for (int i = CFG_W - 1; i >= 0; i--) begin
            if (i < width) begin
                if (!stop && field[i]) run++;
                else                   stop = 1'b1;
            end
        end
        return run;
    endfunction

endpackage

// File: rtl/dbk_regs.sv
`timescale 1ns/1ps
module dbk_regs
    import dbk_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6,
    parameter int SEL_W  = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_we,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic                           cfg_kind,
    input  logic [CFG_W-1:0]               cfg_wdata,
    output logic [NUM_CH-1:0][ADDR_W-1:0]  ch_addr,
    output logic [NUM_CH-1:0][MASK_W-1:0]  ch_cmp,
    output logic [NUM_CH-1:0]              ch_st,
    output logic [NUM_CH-1:0]              ch_ld
);

    localparam logic [MASK_W-1:0] ALL_ONES = {MASK_W{1'b1}};

    // Compare bits for the low field after truncation at the highest zero.
    logic [MASK_W-1:0] cmp_decoded;
    always_comb begin
        cmp_decoded = ~(ALL_ONES >> top_run(cfg_wdata, MASK_W));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_me;
        assign sel_me = cfg_we && (cfg_sel == SEL_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_addr[c] <= '0;
                ch_cmp[c]  <= '0;
                ch_st[c]   <= 1'b0;
                ch_ld[c]   <= 1'b0;
            end else if (sel_me) begin
                if (cfg_kind == CFG_ADDR) begin
                    ch_addr[c] <= cfg_wdata[ADDR_W-1:0];
                end else begin
                    ch_cmp[c] <= cmp_decoded;
                    ch_st[c]  <= cfg_wdata[ST_EN_BIT];
                    ch_ld[c]  <= cfg_wdata[LD_EN_BIT];
                end
            end
        end
    end

endmodule

// File: rtl/dbk_match.sv
`timescale 1ns/1ps
module dbk_match #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] watch_addr,
    input  logic [MASK_W-1:0] watch_cmp,
    input  logic              watch_st,
    input  logic              watch_ld,
    output logic              hit
);

    localparam int HI_W = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] full_mask;
    logic              kind_ok;
    logic              addr_ok;

    always_comb begin
        full_mask = {{HI_W{1'b1}}, watch_cmp};
        kind_ok   = (acc_wr && watch_st) || (acc_rd && watch_ld);
        addr_ok   = ((acc_addr ^ watch_addr) & full_mask) == '0;
        hit       = acc_valid && kind_ok && addr_ok;
    end

endmodule

// File: rtl/dbk_prio.sv
`timescale 1ns/1ps
module dbk_prio #(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 1
) (
    input  logic [NUM_CH-1:0] hit_vec,
    output logic              any_hit,
    output logic [SEL_W-1:0]  first_idx
);

    always_comb begin
        any_hit   = |hit_vec;
        first_idx = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (hit_vec[c]) first_idx = SEL_W'(c);
        end
    end

endmodule

// File: rtl/dbk_comparator.sv
`timescale 1ns/1ps
module dbk_comparator
    import dbk_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_kind,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    output logic              brk_hit,
    output logic [SEL_W-1:0]  brk_chan
);

    logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
    logic [NUM_CH-1:0][MASK_W-1:0] ch_cmp;
    logic [NUM_CH-1:0]             ch_st;
    logic [NUM_CH-1:0]             ch_ld;
    logic [NUM_CH-1:0]             hit_vec;

    dbk_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .MASK_W(MASK_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_kind  (cfg_kind),
        .cfg_wdata (cfg_wdata),
        .ch_addr   (ch_addr),
        .ch_cmp    (ch_cmp),
        .ch_st     (ch_st),
        .ch_ld     (ch_ld)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_match
        dbk_match #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_match (
            .acc_valid  (acc_valid),
            .acc_addr   (acc_addr),
            .acc_rd     (acc_rd),
            .acc_wr     (acc_wr),
            .watch_addr (ch_addr[c]),
            .watch_cmp  (ch_cmp[c]),
            .watch_st   (ch_st[c]),
            .watch_ld   (ch_ld[c]),
            .hit        (hit_vec[c])
        );
    end

    dbk_prio #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_prio (
        .hit_vec   (hit_vec),
        .any_hit   (brk_hit),
        .first_idx (brk_chan)
    );

endmodule

// File: rtl/dbk_comparator_chk.sv
`timescale 1ns/1ps
module dbk_comparator_chk #(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              brk_hit,
    input logic [SEL_W-1:0]  brk_chan,
    input logic [NUM_CH-1:0] hit_vec
);

    // R8: no break without a valid access
    a_r8_valid_gate: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !brk_hit);

    // R3 R4: a break needs a read or a write
    a_r4_needs_kind: assert property (@(posedge clk) disable iff (rst)
        brk_hit |-> (acc_rd || acc_wr));

    // R1: channels come out of reset inactive
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !brk_hit);

    // R9: reported channel is in range and is itself hitting
    a_r9_chan_in_range: assert property (@(posedge clk) disable iff (rst)
        brk_hit |-> (int'(brk_chan) < NUM_CH) && hit_vec[brk_chan]);

    // R9: no lower channel is hitting
    a_r9_lowest_first: assert property (@(posedge clk) disable iff (rst)
        brk_hit |-> (hit_vec & ((NUM_CH'(1) << brk_chan) - NUM_CH'(1))) == '0);

    // R9: idle channel number is zero
    a_r9_idle_chan_zero: assert property (@(posedge clk) disable iff (rst)
        !brk_hit |-> brk_chan == '0);

endmodule

bind dbk_comparator dbk_comparator_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .brk_hit   (brk_hit),
    .brk_chan  (brk_chan),
    .hit_vec   (hit_vec)
);

// File: tb/test_dbk_comparator.sv
`timescale 1ns/1ps
module test_dbk_comparator;

    localparam int NCH = 3;
    localparam int SW  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_sel = '0;
    logic          cfg_kind = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          acc_valid = 1'b0;
    logic [31:0]   acc_addr = '0;
    logic          acc_rd = 1'b0;
    logic          acc_wr = 1'b0;
    logic          brk_hit;
    logic [SW-1:0] brk_chan;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dbk_comparator #(.NUM_CH(NCH), .ADDR_W(32), .MASK_W(6)) i_dbk_comparator (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .brk_hit(brk_hit), .brk_chan(brk_chan)
    );

    task automatic cfg_write(input int sel, input logic kind, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_kind = kind; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic eh, input int ec);
        n_chk++;
        if (brk_hit !== eh || int'(brk_chan) != ec) begin
            n_fail++;
            $display("FAIL %s: hit=%0b chan=%0d expected hit=%0b chan=%0d",
                     tag, brk_hit, brk_chan, eh, ec);
        end
    endtask

    task automatic probe(input string tag, input logic [31:0] a, input logic v,
                         input logic rd, input logic wr, input logic eh, input int ec);
        @(negedge clk);
        acc_addr = a; acc_valid = v; acc_rd = rd; acc_wr = wr;
        #1;
        expect_out(tag, eh, ec);
    endtask

    task automatic t_reset;
        probe("R1 reset idle", 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    endtask

    task automatic t_store;
        cfg_write(0, 1'b0, 32'h1000_0040);
        cfg_write(0, 1'b1, 32'h8000_003F);
        probe("R3 write hit", 32'h1000_0040, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        probe("R3 read ignored", 32'h1000_0040, 1'b1, 1'b1, 1'b0, 1'b0, 0);
        probe("R6 exact miss", 32'h1000_0041, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_load;
        cfg_write(1, 1'b0, 32'h2000_0000);
        cfg_write(1, 1'b1, 32'h4000_003F);
        probe("R4 read hit", 32'h2000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1);
        probe("R4 write ignored", 32'h2000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_both;
        probe("R10 rw on load chan", 32'h2000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1);
        probe("R10 rw on store chan", 32'h1000_0040, 1'b1, 1'b1, 1'b1, 1'b1, 0);
    endtask

    task automatic t_inactive;
        cfg_write(1, 1'b1, 32'h0000_003F);
        probe("R5 inactive", 32'h2000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    endtask

    task automatic t_valid;
        probe("R8 no valid", 32'h1000_0040, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        probe("R8 same cycle", 32'h1000_0040, 1'b1, 1'b0, 1'b1, 1'b1, 0);
    endtask

    task automatic t_mask;
        cfg_write(0, 1'b1, 32'h8000_0038);
        probe("R6 low3 ignored", 32'h1000_0047, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        probe("R6 bit3 compared", 32'h1000_0048, 1'b1, 1'b0, 1'b1, 1'b0, 0);
        cfg_write(0, 1'b0, 32'h1000_0045);
        probe("R6 stored low masked", 32'h1000_0040, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        cfg_write(0, 1'b1, 32'h8000_0000);
        probe("R6 field zero", 32'h1000_007F, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        probe("R6 bit7 compared", 32'h1000_00C5, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_trunc;
        cfg_write(0, 1'b0, 32'h1000_0044);
        cfg_write(0, 1'b1, 32'h8000_0034);
        probe("R7 bit2 dropped", 32'h1000_0040, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        probe("R7 low4 ignored", 32'h1000_004F, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        probe("R7 bit4 kept", 32'h1000_0050, 1'b1, 1'b0, 1'b1, 1'b0, 0);
        cfg_write(0, 1'b1, 32'h8000_001F);
        probe("R7 top zero", 32'h1000_007F, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        probe("R7 bit6 kept", 32'h1000_0004, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_prio;
        cfg_write(0, 1'b0, 32'h3000_0000);
        cfg_write(0, 1'b1, 32'h8000_003F);
        cfg_write(1, 1'b0, 32'h3000_0000);
        cfg_write(1, 1'b1, 32'h8000_003F);
        cfg_write(2, 1'b0, 32'h3000_0000);
        cfg_write(2, 1'b1, 32'hC000_003F);
        probe("R9 three hit", 32'h3000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        cfg_write(0, 1'b1, 32'h0000_003F);
        probe("R9 two hit", 32'h3000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1);
        cfg_write(1, 1'b1, 32'h0000_003F);
        probe("R9 one hit", 32'h3000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 2);
    endtask

    task automatic t_timing;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SW'(2); cfg_kind = 1'b0; cfg_wdata = 32'h4000_0000;
        acc_addr = 32'h4000_0000; acc_valid = 1'b1; acc_rd = 1'b1; acc_wr = 1'b0;
        #1;
        expect_out("R2 old value in write cycle", 1'b0, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        expect_out("R2 new value next cycle", 1'b1, 2);
    endtask

    task automatic t_oob;
        cfg_write(3, 1'b0, 32'h5000_0000);
        cfg_write(3, 1'b1, 32'hC000_003F);
        probe("R11 no phantom chan", 32'h5000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 0);
        probe("R11 chan2 intact", 32'h4000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 2);
        probe("R11 chan0 intact", 32'h3000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_store;
        t_load;
        t_both;
        t_inactive;
        t_valid;
        t_mask;
        t_trunc;
        t_prio;
        t_timing;
        t_oob;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule